// File: doc/BRIEF.md
# Four-Group Severity-Classified Interrupt Aggregator

The block collects 128 hardware event sources, arranged as four groups of 32, into latched cause bits. Each bit can be captured on a level or on a rising edge. A cause bit stays set until software clears it. Software clears a bit by writing a 0 to its position, or by a read when clear-on-read is enabled. When a hardware capture and a software clear land in the same cycle, the capture wins, so no event is lost.

Every group carries four severity masks: error, abort, fatal and log. An unmasked cause bit contributes to each severity line that its own mask lets through. A single bit can therefore raise several severities at once. Each group also drives a summary line, which a control bit can suppress. One registered NMI-style output combines all severity and summary lines, so a parent controller sees a single wire. Software reaches the registers through a zero-wait-state APB slave port.

Top module: `intagg_top`

## Requirements
- R1: Group g's registers sit at byte address g*0x40 plus the offset. The offsets are: cause 0x00, cause-set 0x08, mask 0x10, mask-clear 0x18, status 0x20, control 0x28, error mask 0x2C, abort mask 0x30, fatal mask 0x34, log mask 0x38, edge select 0x3C. A write reaches only the addressed group.
- R2: After reset the cause, edge-select and control bits are 0. The mask and all four severity masks read 0xFFFFFFFF. All outputs are low.
- R3: Writing to the cause register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R4: If a source captures into a cause bit in the same cycle that software clears that bit, the bit ends up set.
- R5: Writing to cause-set sets each cause bit written as 1. Bits written as 0 have no effect.
- R6: Writing to mask-clear clears each mask bit written as 0. Mask bits written as 1 keep their value.
- R7: Each severity output (error, abort, fatal, log) is the OR over all groups and bits of cause AND NOT mask AND NOT that severity's mask.
- R8: Group summary g is the OR of cause AND NOT mask for that group. It is forced low while control bit 5 is 1.
- R9: nmiOut equals the OR of all severity outputs and all group summaries, delayed by one clock.
- R10: With control bit 0 set, a read of the cause register returns its value and then clears all of that group's cause bits.
- R11: An edge-select bit of 1, or control bit 3 for the whole group, captures a source only on a rising edge. Otherwise a high source sets the cause bit on every cycle. The status register returns the source value sampled at the last clock.
- R12: With control bit 1 set, a hardware capture also sets that bit's mask bit.
- R13: Control bits [29:28] read as 1 and ignore writes. Only control bits 0, 1, 3 and 5 are writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| srcIn | input | 128 | Hardware sources, group g at bits [32g+31:32g] |
| errorOut | output | 1 | Error severity line |
| abortOut | output | 1 | Abort severity line |
| fatalOut | output | 1 | Fatal severity line |
| logOut | output | 1 | Log severity line |
| groupSummary | output | 4 | Per-group summary lines |
| nmiOut | output | 1 | Registered combined interrupt |

## Verification
Sources are driven in three ways: held high in level mode, held high in edge mode, and pulsed for one cycle inside an APB clear. Comparing the level and edge cases shows whether a held source re-arms after a clear. The pulse isolates the hardware-wins rule. Severity lines are checked with one live bit while its masks are opened one at a time, which shows that the masks are independent and that the main mask gates all of them. The NMI output is sampled on both sides of its register to confirm the one-cycle lag.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  parameter int unsigned GRP_N     = 4;
  parameter int unsigned SRC_W     = 32;
  parameter int unsigned SEV_N     = 4;
  parameter int unsigned GRP_BYTES = 64;

  localparam int unsigned OFF_W  = $clog2(GRP_BYTES);
  localparam int unsigned GIDX_W = $clog2(GRP_N);
  localparam int unsigned ADDR_W = OFF_W + GIDX_W;
  localparam int unsigned SEVI_W = $clog2(SEV_N);
  localparam int unsigned SRC_ALL = GRP_N * SRC_W;

  localparam logic [OFF_W-1:0] OFF_CAUSE  = OFF_W'('h00);
  localparam logic [OFF_W-1:0] OFF_CSET   = OFF_W'('h08);
  localparam logic [OFF_W-1:0] OFF_MASK   = OFF_W'('h10);
  localparam logic [OFF_W-1:0] OFF_MCLR   = OFF_W'('h18);
  localparam logic [OFF_W-1:0] OFF_STAT   = OFF_W'('h20);
  localparam logic [OFF_W-1:0] OFF_CTRL   = OFF_W'('h28);
  localparam logic [OFF_W-1:0] OFF_SEV0   = OFF_W'('h2C);
  localparam logic [OFF_W-1:0] OFF_SEVL   = OFF_W'('h38);
  localparam logic [OFF_W-1:0] OFF_EDGE   = OFF_W'('h3C);

  localparam int unsigned CB_CLR_ON_READ = 0;
  localparam int unsigned CB_AUTO_MASK   = 1;
  localparam int unsigned CB_POS_EDGE    = 3;
  localparam int unsigned CB_NO_SUMMARY  = 5;
  localparam int unsigned CB_REV_LO      = 28;
  localparam logic [1:0]  REV_ID         = 2'd1;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CAUSE, SEL_CSET, SEL_MASK, SEL_MCLR,
    SEL_STAT, SEL_CTRL, SEL_SEV, SEL_EDGE
  } regSel_t;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [GRP_N-1:0]  grpHit;
    logic [GIDX_W-1:0] grpIdx;
    regSel_t           sel;
    logic [SEVI_W-1:0] sevIdx;
  } strobe_t;

  typedef struct packed {
    logic noSummary;
    logic posEdge;
    logic autoMask;
    logic clrOnRead;
  } ctrl_t;
endpackage

// File: rtl/intagg_ctrl.sv
module intagg_ctrl
  import intagg_pkg::*;
(
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output strobe_t           stb
);
  logic             access;
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] sevOff;

  always_comb begin
    access     = psel & penable;
    off        = paddr[OFF_W-1:0];
    sevOff     = off - OFF_SEV0;
    stb        = '0;
    stb.sel    = SEL_NONE;
    stb.grpIdx = paddr[ADDR_W-1:OFF_W];
    stb.wr     = access & pwrite;
    stb.rd     = access & ~pwrite;
    stb.sevIdx = sevOff[SEVI_W+1:2];
    for (int g = 0; g < GRP_N; g++)
      stb.grpHit[g] = access && (stb.grpIdx == GIDX_W'(g));
    if (off == OFF_CAUSE)      stb.sel = SEL_CAUSE;
    else if (off == OFF_CSET)  stb.sel = SEL_CSET;
    else if (off == OFF_MASK)  stb.sel = SEL_MASK;
    else if (off == OFF_MCLR)  stb.sel = SEL_MCLR;
    else if (off == OFF_STAT)  stb.sel = SEL_STAT;
    else if (off == OFF_CTRL)  stb.sel = SEL_CTRL;
    else if (off == OFF_EDGE)  stb.sel = SEL_EDGE;
    else if (off >= OFF_SEV0 && off <= OFF_SEVL && off[1:0] == 2'b00)
      stb.sel = SEL_SEV;
  end

  // R1: an access hits exactly one group, idle hits none
  p_one_group_r1: assert property (@(posedge pclk) disable iff (!presetn)
    (stb.wr || stb.rd) |-> ($countones(stb.grpHit) == 1));
  p_idle_none_r1: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable) |-> (stb.grpHit == '0));
endmodule

// File: rtl/intagg_datapath.sv
module intagg_datapath
  import intagg_pkg::*;
(
  input  logic               pclk,
  input  logic               presetn,
  input  strobe_t            stb,
  input  logic [SRC_W-1:0]   wdata,
  input  logic [SRC_ALL-1:0] srcIn,
  output logic [SRC_W-1:0]   rdata,
  output logic [SEV_N-1:0]   sevOut,
  output logic [GRP_N-1:0]   groupSum
);
  logic [SRC_W-1:0] srcGrp  [GRP_N];
  logic [SRC_W-1:0] cause   [GRP_N];
  logic [SRC_W-1:0] mask    [GRP_N];
  logic [SRC_W-1:0] edgeSel [GRP_N];
  logic [SRC_W-1:0] srcPrev [GRP_N];
  ctrl_t            ctrlR   [GRP_N];
  logic [SRC_W-1:0] sevMask [GRP_N][SEV_N];

  logic [SRC_W-1:0] hwSet    [GRP_N];
  logic [SRC_W-1:0] causeNxt [GRP_N];
  logic [SRC_W-1:0] maskNxt  [GRP_N];
  logic [SRC_W-1:0] edgeNxt  [GRP_N];
  ctrl_t            ctrlNxt  [GRP_N];
  logic [SRC_W-1:0] sevNxt   [GRP_N][SEV_N];
  logic [SRC_W-1:0] edgeEff;
  logic             wrHit;
  logic             rdHit;

  for (genvar g = 0; g < GRP_N; g++) begin : gSlice
    assign srcGrp[g]   = srcIn[g*SRC_W +: SRC_W];
    assign groupSum[g] = ~ctrlR[g].noSummary & (|(cause[g] & ~mask[g]));
  end

  always_comb begin
    edgeEff = '0;
    wrHit   = 1'b0;
    rdHit   = 1'b0;
    for (int g = 0; g < GRP_N; g++) begin
      wrHit    = stb.grpHit[g] & stb.wr;
      rdHit    = stb.grpHit[g] & stb.rd;
      edgeEff  = edgeSel[g] | {SRC_W{ctrlR[g].posEdge}};
      hwSet[g] = srcGrp[g] & ~(edgeEff & srcPrev[g]);

      causeNxt[g] = cause[g];
      if (wrHit && stb.sel == SEL_CAUSE) causeNxt[g] = causeNxt[g] & wdata;
      if (wrHit && stb.sel == SEL_CSET)  causeNxt[g] = causeNxt[g] | wdata;
      if (rdHit && stb.sel == SEL_CAUSE && ctrlR[g].clrOnRead) causeNxt[g] = '0;
      causeNxt[g] = causeNxt[g] | hwSet[g];

      maskNxt[g] = mask[g];
      if (wrHit && stb.sel == SEL_MASK) maskNxt[g] = wdata;
      if (wrHit && stb.sel == SEL_MCLR) maskNxt[g] = mask[g] & wdata;
      if (ctrlR[g].autoMask) maskNxt[g] = maskNxt[g] | hwSet[g];

      edgeNxt[g] = (wrHit && stb.sel == SEL_EDGE) ? wdata : edgeSel[g];

      ctrlNxt[g] = ctrlR[g];
      if (wrHit && stb.sel == SEL_CTRL) begin
        ctrlNxt[g].clrOnRead = wdata[CB_CLR_ON_READ];
        ctrlNxt[g].autoMask  = wdata[CB_AUTO_MASK];
        ctrlNxt[g].posEdge   = wdata[CB_POS_EDGE];
        ctrlNxt[g].noSummary = wdata[CB_NO_SUMMARY];
      end

      for (int s = 0; s < SEV_N; s++)
        sevNxt[g][s] = (wrHit && stb.sel == SEL_SEV && stb.sevIdx == SEVI_W'(s))
                       ? wdata : sevMask[g][s];
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      for (int g = 0; g < GRP_N; g++) begin
        cause[g]   <= '0;
        mask[g]    <= '1;
        edgeSel[g] <= '0;
        srcPrev[g] <= '0;
        ctrlR[g]   <= '0;
        for (int s = 0; s < SEV_N; s++) sevMask[g][s] <= '1;
      end
    end else begin
      for (int g = 0; g < GRP_N; g++) begin
        cause[g]   <= causeNxt[g];
        mask[g]    <= maskNxt[g];
        edgeSel[g] <= edgeNxt[g];
        srcPrev[g] <= srcGrp[g];
        ctrlR[g]   <= ctrlNxt[g];
        for (int s = 0; s < SEV_N; s++) sevMask[g][s] <= sevNxt[g][s];
      end
    end
  end

  always_comb begin
    sevOut = '0;
    for (int g = 0; g < GRP_N; g++)
      for (int s = 0; s < SEV_N; s++)
        sevOut[s] = sevOut[s] | (|(cause[g] & ~mask[g] & ~sevMask[g][s]));
  end

  always_comb begin
    rdata = '0;
    case (stb.sel)
      SEL_CAUSE: rdata = cause[stb.grpIdx];
      SEL_MASK:  rdata = mask[stb.grpIdx];
      SEL_STAT:  rdata = srcPrev[stb.grpIdx];
      SEL_EDGE:  rdata = edgeSel[stb.grpIdx];
      SEL_SEV:   rdata = sevMask[stb.grpIdx][stb.sevIdx];
      SEL_CTRL: begin
        rdata[CB_REV_LO +: 2]  = REV_ID;
        rdata[CB_CLR_ON_READ]  = ctrlR[stb.grpIdx].clrOnRead;
        rdata[CB_AUTO_MASK]    = ctrlR[stb.grpIdx].autoMask;
        rdata[CB_POS_EDGE]     = ctrlR[stb.grpIdx].posEdge;
        rdata[CB_NO_SUMMARY]   = ctrlR[stb.grpIdx].noSummary;
      end
      default:   rdata = '0;
    endcase
  end

  for (genvar g = 0; g < GRP_N; g++) begin : gChk
    // R4: a capture always survives into the next cycle
    p_hw_wins_r4: assert property (@(posedge pclk) disable iff (!presetn)
      (|hwSet[g]) |=> ((cause[g] & $past(hwSet[g])) == $past(hwSet[g])));
    // R5: bits written as 1 to cause-set are present afterwards
    p_set_w1s_r5: assert property (@(posedge pclk) disable iff (!presetn)
      (stb.grpHit[g] && stb.wr && stb.sel == SEL_CSET)
      |=> ((cause[g] & $past(wdata)) == $past(wdata)));
    // R3: a cause write never drops a bit written as 1
    p_w0c_keep_r3: assert property (@(posedge pclk) disable iff (!presetn)
      (stb.grpHit[g] && stb.wr && stb.sel == SEL_CAUSE)
      |=> ((~cause[g] & $past(cause[g] & wdata)) == '0));
    // R6: mask-clear can only lower mask bits
    p_mask_clear_r6: assert property (@(posedge pclk) disable iff (!presetn)
      (stb.grpHit[g] && stb.wr && stb.sel == SEL_MCLR && !ctrlR[g].autoMask)
      |=> ((mask[g] & ~$past(mask[g])) == '0));
  end
endmodule

// File: rtl/intagg_top.sv
module intagg_top
  import intagg_pkg::*;
(
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [SRC_W-1:0]   pwdata,
  output logic [SRC_W-1:0]   prdata,
  input  logic [SRC_ALL-1:0] srcIn,
  output logic               errorOut,
  output logic               abortOut,
  output logic               fatalOut,
  output logic               logOut,
  output logic [GRP_N-1:0]   groupSummary,
  output logic               nmiOut
);
  strobe_t          stb;
  logic [SEV_N-1:0] sevOut;
  logic             anyLine;

  intagg_ctrl u_ctrl (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .stb     (stb)
  );

  intagg_datapath u_dp (
    .pclk     (pclk),
    .presetn  (presetn),
    .stb      (stb),
    .wdata    (pwdata),
    .srcIn    (srcIn),
    .rdata    (prdata),
    .sevOut   (sevOut),
    .groupSum (groupSummary)
  );

  assign errorOut = sevOut[0];
  assign abortOut = sevOut[1];
  assign fatalOut = sevOut[2];
  assign logOut   = sevOut[3];
  assign anyLine  = (|sevOut) | (|groupSummary);

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) nmiOut <= 1'b0;
    else          nmiOut <= anyLine;
  end

  // R9: nmiOut stays low one cycle after all lines are quiet, high after any is active
  p_nmi_quiet_r9: assert property (@(posedge pclk) disable iff (!presetn)
    !anyLine |=> !nmiOut);
  p_nmi_active_r9: assert property (@(posedge pclk) disable iff (!presetn)
    (|sevOut) |=> nmiOut);
endmodule

// File: tb/intagg_top_tb.sv
module intagg_top_tb;
  localparam int CLK_PERIOD = 10;

  logic         pclk = 1'b0;
  logic         presetn = 1'b0;
  logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]   paddr = '0;
  logic [31:0]  pwdata = '0;
  logic [31:0]  prdata;
  logic [127:0] srcIn = '0;
  logic         errorOut, abortOut, fatalOut, logOut, nmiOut;
  logic [3:0]   groupSummary;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  intagg_top u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .srcIn(srcIn), .errorOut(errorOut), .abortOut(abortOut),
    .fatalOut(fatalOut), .logOut(logOut), .groupSummary(groupSummary),
    .nmiOut(nmiOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1;
    #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    apbRead(a, v);
    chk(tag, v, exp);
  endtask

  task automatic testReset();
    chk("R2 outputs", {27'd0, errorOut, abortOut, fatalOut, logOut, nmiOut}, 32'd0);
    chk("R2 summary", {28'd0, groupSummary}, 32'd0);
    rdChk("R2 cause g0", 8'h00, 32'h0);
    rdChk("R2 mask g3", 8'hD0, 32'hFFFFFFFF);
    rdChk("R2 log mask g2", 8'hB8, 32'hFFFFFFFF);
    rdChk("R2 abort mask g1", 8'h70, 32'hFFFFFFFF);
    rdChk("R2 ctrl g0", 8'h28, 32'h10000000);
    rdChk("R2 edge g1", 8'h7C, 32'h0);
  endtask

  task automatic testMap();
    apbWrite(8'h90, 32'h12345678);
    rdChk("R1 mask g2", 8'h90, 32'h12345678);
    rdChk("R1 mask g0 untouched", 8'h10, 32'hFFFFFFFF);
    rdChk("R1 mask g3 untouched", 8'hD0, 32'hFFFFFFFF);
    apbWrite(8'h90, 32'hFFFFFFFF);
  endtask

  task automatic testLevel();
    @(negedge pclk); srcIn[35] = 1;
    @(negedge pclk);
    rdChk("R11 status high", 8'h60, 32'h8);
    rdChk("R2 level cause g1", 8'h40, 32'h8);
    srcIn[35] = 0;
    @(negedge pclk);
    rdChk("R2 cause stays latched", 8'h40, 32'h8);
    rdChk("R11 status low", 8'h60, 32'h0);
  endtask

  task automatic testW0c();
    apbWrite(8'h40, 32'hFFFFFFFF);
    rdChk("R3 write 1 keeps", 8'h40, 32'h8);
    apbWrite(8'h40, 32'hFFFFFFF7);
    rdChk("R3 write 0 clears", 8'h40, 32'h0);
  endtask

  task automatic testW1s();
    apbWrite(8'h88, 32'h0);
    rdChk("R5 write 0 no effect", 8'h80, 32'h0);
    apbWrite(8'h88, 32'h5);
    rdChk("R5 set bits", 8'h80, 32'h5);
    apbWrite(8'h88, 32'h2);
    rdChk("R5 set ORs in", 8'h80, 32'h7);
    apbWrite(8'h80, 32'h0);
    rdChk("R3 clear all g2", 8'h80, 32'h0);
  endtask

  task automatic testMaskClr();
    apbWrite(8'h18, 32'hFFFFFFFE);
    rdChk("R6 clears bit0", 8'h10, 32'hFFFFFFFE);
    apbWrite(8'h18, 32'hFFFFFFFF);
    rdChk("R6 ones keep", 8'h10, 32'hFFFFFFFE);
  endtask

  task automatic testSeverity();
    apbWrite(8'h08, 32'h1);
    chk("R7 all sev masked", {28'd0, errorOut, abortOut, fatalOut, logOut}, 32'h0);
    apbWrite(8'h2C, 32'hFFFFFFFE);
    chk("R7 error only", {28'd0, errorOut, abortOut, fatalOut, logOut}, 32'h8);
    apbWrite(8'h34, 32'hFFFFFFFE);
    chk("R7 error+fatal", {28'd0, errorOut, abortOut, fatalOut, logOut}, 32'hA);
    apbWrite(8'h10, 32'hFFFFFFFF);
    chk("R7 main mask gates", {28'd0, errorOut, abortOut, fatalOut, logOut}, 32'h0);
    chk("R8 masked summary", {28'd0, groupSummary}, 32'h0);
    apbWrite(8'h10, 32'hFFFFFFFE);
  endtask

  task automatic testSummaryNmi();
    chk("R8 summary live", {28'd0, groupSummary}, 32'h1);
    @(negedge pclk);
    chk("R9 nmi high", {31'd0, nmiOut}, 32'h1);
    apbWrite(8'h28, 32'h20);
    chk("R8 summary suppressed", {28'd0, groupSummary}, 32'h0);
    apbWrite(8'h2C, 32'hFFFFFFFF);
    apbWrite(8'h34, 32'hFFFFFFFF);
    chk("R9 nmi lags one cycle", {31'd0, nmiOut}, 32'h1);
    @(negedge pclk);
    chk("R9 nmi drops", {31'd0, nmiOut}, 32'h0);
    apbWrite(8'h28, 32'h0);
    chk("R8 summary back", {28'd0, groupSummary}, 32'h1);
    apbWrite(8'h00, 32'h0);
    chk("R8 summary after clear", {28'd0, groupSummary}, 32'h0);
  endtask

  task automatic testClrOnRead();
    apbWrite(8'h88, 32'h30);
    apbWrite(8'hA8, 32'h1);
    rdChk("R10 read returns value", 8'h80, 32'h30);
    rdChk("R10 read cleared", 8'h80, 32'h0);
    apbWrite(8'hA8, 32'h0);
  endtask

  task automatic testEdge();
    apbWrite(8'hFC, 32'h1);
    @(negedge pclk); srcIn[96] = 1; srcIn[97] = 1;
    @(negedge pclk);
    apbWrite(8'hC0, 32'h0);
    rdChk("R11 edge not rearmed, level rearmed", 8'hC0, 32'h2);
    apbWrite(8'hE8, 32'h8);
    apbWrite(8'hC0, 32'h0);
    rdChk("R11 group posedge", 8'hC0, 32'h0);
    srcIn[96] = 0; srcIn[97] = 0;
    @(negedge pclk);
  endtask

  task automatic testCollision();
    @(negedge pclk); psel = 1; pwrite = 1; paddr = 8'hC0; pwdata = 32'h0; penable = 0;
    @(negedge pclk); penable = 1; srcIn[96] = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0; srcIn[96] = 0;
    rdChk("R4 hw set wins", 8'hC0, 32'h1);
    apbWrite(8'hC0, 32'h0);
    rdChk("R4 later clear works", 8'hC0, 32'h0);
  endtask

  task automatic testAutoMask();
    apbWrite(8'h50, 32'hFFFFFFF7);
    apbWrite(8'h68, 32'h2);
    @(negedge pclk); srcIn[35] = 1;
    @(negedge pclk); srcIn[35] = 0;
    rdChk("R12 mask re-set", 8'h50, 32'hFFFFFFFF);
    rdChk("R12 cause latched", 8'h40, 32'h8);
  endtask

  task automatic testRev();
    apbWrite(8'h68, 32'hFFFFFFFF);
    rdChk("R13 writable bits", 8'h68, 32'h1000002B);
    apbWrite(8'h68, 32'h0);
    rdChk("R13 rev survives zero", 8'h68, 32'h10000000);
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);
    testReset();
    testMap();
    testLevel();
    testW0c();
    testW1s();
    testMaskClr();
    testSeverity();
    testSummaryNmi();
    testClrOnRead();
    testEdge();
    testCollision();
    testAutoMask();
    testRev();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge pclk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule